// File: doc/BRIEF.md
# Floating-Point Squarer

The block squares a small floating-point value whose mantissa is a signed, normalized fraction and whose exponent is a signed integer. A caller places the operand on `frac_in` and `exp_in` and pulses `start`. A state-machine controller then runs the job and drives a single-cycle `done` along with a normalized result fraction, its exponent and two range flags. The result holds until the next job finishes.

The square of a negative fraction equals the square of its magnitude, so the controller first turns a negative fraction into its positive magnitude. Negation, exponent doubling and the later ±1 exponent correction all run on one shared adder, whose second operand passes through one shared complementer. The unsigned multiply of the magnitude by itself is done by a separate shift-add unit. That unit has its own start/finish handshake, and the controller waits on it in a dedicated state.

The fraction `s.ffff` has value `frac/16` in two's complement. A normalized non-zero fraction has its top two bits differing: `01xxx` is positive, `10xxx` is negative. The exponent is a 5-bit two's-complement integer covering -16..15.

Top module: `fpsq_squarer`

## Requirements
- R1: During and after a synchronous active-low reset, with no job run yet, `done`, `ovf`, `unf`, `frac_out` and `exp_out` are all zero.
- R2: For a positive normalized fraction with magnitude m (m = 8..15, value m/16), let p = m*m. If p >= 128, the result fraction is 0 followed by p[7:4] and the exponent is 2E. Otherwise the product is shifted left once: the fraction is 0 followed by p[6:3] and the exponent is 2E-1. `done` rises 9 clocks after the edge that samples `start` when no shift is needed, and 10 clocks after it when the shift is needed.
- R3: A negative normalized fraction other than 10000 gives the same fraction and exponent as its positive magnitude. `done` comes one clock later than for that magnitude.
- R4: Fraction 00000 skips the multiply and returns fraction 00000 with exponent 00000. `done` rises 2 clocks after the sampling edge.
- R5: Fraction 10000 (value -1) skips the multiply and returns fraction 01000 with exponent 2E+1. `done` rises 4 clocks after the sampling edge.
- R6: Every result fraction is either 00000 with exponent 00000, or has the form 01xxx.
- R7: If the true result exponent exceeds 15, `ovf` is 1 with `done`. `exp_out` then carries the low 5 bits of the true exponent.
- R8: If the true result exponent is below -16, `unf` is 1 with `done`. `exp_out` then carries the low 5 bits. `ovf` and `unf` are never both 1.
- R9: `done` lasts exactly one clock per job. `frac_out`, `exp_out`, `ovf` and `unf` change only in the clock where `done` is 1.
- R10: A `start` pulse that arrives while a job is in progress is ignored. Only the first job's result appears, and it comes with a single `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a job with the present operand (sampled while idle) |
| frac_in | input | 5 | Operand fraction, two's complement s.ffff |
| exp_in | input | 5 | Operand exponent, two's complement |
| done | output | 1 | One-clock pulse when a result is ready |
| frac_out | output | 5 | Normalized result fraction |
| exp_out | output | 5 | Result exponent, low 5 bits of the true value |
| ovf | output | 1 | Result exponent above the 5-bit range |
| unf | output | 1 | Result exponent below the 5-bit range |

## Verification
The result is due a fixed number of clocks after the edge that samples `start`: 2 for a zero fraction, 4 for -1, and 9 or 10 for a positive fraction depending on whether a normalizing shift is needed, with one more clock for a negative fraction. When the driver raises `start`, it notes the current cycle count. It then adds the latency taken from the requirement for that operand and queues the expected item with this due cycle. The monitor samples on falling edges, pops the queue on each `done`, and compares the values and the arrival cycle against the queued item. A stray `done`, or one that comes early or late, is reported against the requirement that fixes that timing.

// File: rtl/fpsq_pkg.sv
// Package fpsq_pkg
// Shared controller state encoding for the floating-point squarer.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package fpsq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,    // waiting for start
        ST_CLASS,   // classify fraction: zero, minus one, sign
        ST_NEG,     // adder forms magnitude of a negative fraction
        ST_MSTART,  // launch multiplier, adder doubles exponent
        ST_MWAIT,   // wait for multiplier completion
        ST_NORM,    // pick product bits, decide on exponent decrement
        ST_DBL,     // minus-one path: adder doubles exponent
        ST_ADJ,     // adder applies +1 or -1 to exponent
        ST_FIN      // publish result and pulse done
    } sq_state_e;

endpackage

// File: rtl/fpsq_complementer.sv
// Module fpsq_complementer
// Bitwise inverter with an enable; with a carry-in of one on the adder
// this gives two's-complement negation. Assumes W >= 1.
module fpsq_complementer #(
    parameter int W = 7
) (
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // One XOR per bit: invert when enabled, pass through otherwise.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign q[i] = d[i] ^ en;
    end

endmodule

// File: rtl/fpsq_adder.sv
// Module fpsq_adder
// The single shared adder of the squarer datapath: sum = a + b + cin,
// truncated to W bits. Assumes callers supply sign-extended operands.
module fpsq_adder #(
    parameter int W = 7
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum
);

    // Plain ripple-style sum; the width is small.
    always_comb begin
        sum = a + b + W'(cin);
    end

endmodule

// File: rtl/fpsq_shift_mul.sv
// Module fpsq_shift_mul
// Unsigned shift-add multiplier with its own sequencing. A go pulse while
// idle loads the operands. N add/shift steps follow, and done pulses for one
// clock after the last step. The product stays valid until the next go.
// Assumes go is ignored while busy.
module fpsq_shift_mul #(
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    input  logic [N-1:0]   mcand,
    input  logic [N-1:0]   mplier,
    output logic           done,
    output logic [2*N-1:0] product
);

    localparam int CW = $clog2(N + 1);

    logic [N-1:0]  hi_q;
    logic [N-1:0]  lo_q;
    logic [N-1:0]  mc_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic [N:0]    step_sum;

    // Partial-product add for the current multiplier bit.
    always_comb begin
        step_sum = lo_q[0] ? ({1'b0, hi_q} + {1'b0, mc_q}) : {1'b0, hi_q};
    end

    // Load on go, then shift the accumulator pair right once per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q   <= '0;
            lo_q   <= '0;
            mc_q   <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done   <= 1'b0;
        end else if (go && !busy_q) begin
            hi_q   <= '0;
            lo_q   <= mplier;
            mc_q   <= mcand;
            cnt_q  <= CW'(N);
            busy_q <= 1'b1;
            done   <= 1'b0;
        end else if (busy_q) begin
            hi_q  <= step_sum[N:1];
            lo_q  <= {step_sum[0], lo_q[N-1:1]};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
                busy_q <= 1'b0;
                done   <= 1'b1;
            end
        end else begin
            done <= 1'b0;
        end
    end

    assign product = {hi_q, lo_q};

endmodule

// File: rtl/fpsq_squarer.sv
// Module fpsq_squarer
// Squares F x 2^E, where F is a normalized two's-complement fraction of FW
// bits and E a two's-complement exponent of EW bits. A controller schedules
// magnitude, exponent doubling and exponent correction on one adder with one
// complementer, and delegates the fraction product to fpsq_shift_mul.
// Assumes: FW >= 3, EW >= 2, and start is only honoured when idle.
module fpsq_squarer
    import fpsq_pkg::*;
#(
    parameter int FW = 5,
    parameter int EW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [FW-1:0] frac_in,
    input  logic [EW-1:0] exp_in,
    output logic          done,
    output logic [FW-1:0] frac_out,
    output logic [EW-1:0] exp_out,
    output logic          ovf,
    output logic          unf
);

    localparam int MW = FW - 1;               // magnitude bits
    localparam int PW = 2 * MW;               // product bits
    localparam int XW = EW + 2;               // working exponent bits
    localparam int AW = (XW > FW) ? XW : FW;  // shared adder width
    localparam logic signed [XW-1:0] EHI = XW'((2 ** (EW - 1)) - 1);
    localparam logic signed [XW-1:0] ELO = XW'(-(2 ** (EW - 1)));
    localparam logic [FW-1:0] F_MONE = {1'b1, {(FW-1){1'b0}}};
    localparam logic [FW-1:0] F_HALF = {2'b01, {(FW-2){1'b0}}};

    sq_state_e              state_q, state_d;
    logic [FW-1:0]          f_q;
    logic [EW-1:0]          e_q;
    logic [MW-1:0]          mag_q;
    logic signed [XW-1:0]   xexp_q;
    logic [FW-1:0]          xfrac_q;
    logic                   adj_up_q;

    logic [AW-1:0]          add_a, add_s, cmp_d, cmp_q;
    logic                   cmp_en, add_cin;
    logic                   mul_go, mul_done;
    logic [PW-1:0]          product;
    logic                   f_zero, f_mone, f_neg;
    logic                   unused_low;

    assign f_zero     = (f_q == '0);
    assign f_mone     = (f_q == F_MONE);
    assign f_neg      = f_q[FW-1];
    assign mul_go     = (state_q == ST_MSTART);
    assign unused_low = ^product[PW-MW-2:0];

    // Shared resource instances: one complementer feeding one adder.
    fpsq_complementer #(.W(AW)) u_cmp (
        .en (cmp_en),
        .d  (cmp_d),
        .q  (cmp_q)
    );

    fpsq_adder #(.W(AW)) u_add (
        .a   (add_a),
        .b   (cmp_q),
        .cin (add_cin),
        .sum (add_s)
    );

    fpsq_shift_mul #(.N(MW)) u_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (mul_go),
        .mcand   (mag_q),
        .mplier  (mag_q),
        .done    (mul_done),
        .product (product)
    );

    // Operand steering for the shared adder, chosen by controller state.
    always_comb begin
        add_a   = '0;
        cmp_d   = '0;
        cmp_en  = 1'b0;
        add_cin = 1'b0;
        case (state_q)
            ST_NEG: begin
                cmp_d   = AW'($signed(f_q));
                cmp_en  = 1'b1;
                add_cin = 1'b1;
            end
            ST_MSTART, ST_DBL: begin
                add_a = AW'($signed(e_q));
                cmp_d = AW'($signed(e_q));
            end
            ST_ADJ: begin
                add_a   = AW'(xexp_q);
                cmp_d   = AW'(1);
                cmp_en  = !adj_up_q;
                add_cin = !adj_up_q;
            end
            default: ;
        endcase
    end

    // Controller next-state logic.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (start) state_d = ST_CLASS;
            ST_CLASS: begin
                if (f_zero)      state_d = ST_FIN;
                else if (f_mone) state_d = ST_DBL;
                else if (f_neg)  state_d = ST_NEG;
                else             state_d = ST_MSTART;
            end
            ST_NEG:    state_d = ST_MSTART;
            ST_MSTART: state_d = ST_MWAIT;
            ST_MWAIT:  if (mul_done) state_d = ST_NORM;
            ST_NORM:   state_d = product[PW-1] ? ST_FIN : ST_ADJ;
            ST_DBL:    state_d = ST_ADJ;
            ST_ADJ:    state_d = ST_FIN;
            ST_FIN:    state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Controller state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers, each loaded in the state that owns it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q      <= '0;
            e_q      <= '0;
            mag_q    <= '0;
            xexp_q   <= '0;
            xfrac_q  <= '0;
            adj_up_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    f_q <= frac_in;
                    e_q <= exp_in;
                end
                ST_CLASS: begin
                    if (f_zero) begin
                        xfrac_q <= '0;
                        xexp_q  <= '0;
                    end else if (f_mone) begin
                        xfrac_q  <= F_HALF;
                        adj_up_q <= 1'b1;
                    end else if (!f_neg) begin
                        mag_q <= f_q[MW-1:0];
                    end
                end
                ST_NEG:            mag_q  <= add_s[MW-1:0];
                ST_MSTART, ST_DBL: xexp_q <= add_s[XW-1:0];
                ST_NORM: begin
                    adj_up_q <= 1'b0;
                    if (product[PW-1]) xfrac_q <= {1'b0, product[PW-1 -: MW]};
                    else               xfrac_q <= {1'b0, product[PW-2 -: MW]};
                end
                ST_ADJ:            xexp_q <= add_s[XW-1:0];
                default: ;
            endcase
        end
    end

    // Result registers and the one-clock done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            frac_out <= '0;
            exp_out  <= '0;
            ovf      <= 1'b0;
            unf      <= 1'b0;
        end else if (state_q == ST_FIN) begin
            done     <= 1'b1;
            frac_out <= xfrac_q;
            exp_out  <= xexp_q[EW-1:0];
            ovf      <= (xexp_q > EHI);
            unf      <= (xexp_q < ELO);
        end else begin
            done <= 1'b0;
        end
    end

endmodule

// File: rtl/fpsq_checker.sv
// Module fpsq_checker
// Port-level properties of fpsq_squarer, attached with bind below.
// Assumes the same FW and EW as the bound instance.
module fpsq_checker #(
    parameter int FW = 5,
    parameter int EW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic [FW-1:0] frac_out,
    input logic [EW-1:0] exp_out,
    input logic          ovf,
    input logic          unf
);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(frac_out) && $stable(exp_out) && $stable(ovf) && $stable(unf)));

    assert_normalized_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((frac_out == '0 && exp_out == '0) || frac_out[FW-1:FW-2] == 2'b01));

    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf && unf));

    assert_zero_exp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && frac_out == '0) |-> (exp_out == '0 && !ovf && !unf));

endmodule

bind fpsq_squarer fpsq_checker #(.FW(FW), .EW(EW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .frac_out (frac_out),
    .exp_out  (exp_out),
    .ovf      (ovf),
    .unf      (unf)
);

// File: tb/sim_fpsq_squarer.sv
// Scoreboard bench for fpsq_squarer: a driver queues expected results with
// their due cycle, a monitor pops and compares them on each done.
module sim_fpsq_squarer;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [4:0] frac_in = '0;
    logic [4:0] exp_in = '0;
    logic       done;
    logic [4:0] frac_out;
    logic [4:0] exp_out;
    logic       ovf, unf;

    typedef struct {
        logic [4:0] fr;
        logic [4:0] ex;
        logic       ov;
        logic       un;
        int         due;
        string      req;
    } item_t;

    item_t sb[$];
    item_t last;
    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    int    n_done = 0;
    int    n_ops = 0;
    bit    finished = 1'b0;

    fpsq_squarer u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .frac_in(frac_in), .exp_in(exp_in),
        .done(done), .frac_out(frac_out), .exp_out(exp_out), .ovf(ovf), .unf(unf)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, string what, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Expected result from the requirements, with latency in clocks.
    function automatic item_t model(logic [4:0] f, logic [4:0] e, string req, output int lat);
        item_t it;
        int fi, ei, m, p, ee, fr;
        fi = int'($signed(f));
        ei = int'($signed(e));
        if (fi == 0) begin
            fr = 0; ee = 0; lat = 2;                       // R4
        end else if (fi == -16) begin
            fr = 8; ee = 2 * ei + 1; lat = 4;              // R5
        end else begin
            m = (fi < 0) ? -fi : fi;
            p = m * m;
            if (p >= 128) begin fr = p >> 4; ee = 2 * ei;     lat = 9;  end  // R2
            else          begin fr = p >> 3; ee = 2 * ei - 1; lat = 10; end
            if (fi < 0) lat++;                                                // R3
        end
        it.fr  = 5'(fr);
        it.ex  = 5'(ee);
        it.ov  = (ee > 15);
        it.un  = (ee < -16);
        it.req = req;
        it.due = 0;
        return it;
    endfunction

    task automatic run_op(logic [4:0] f, logic [4:0] e, string req, bit intrude);
        item_t it;
        int lat;
        @(negedge clk);
        it = model(f, e, req, lat);
        it.due = cyc + lat + 1;
        sb.push_back(it);
        last = it;
        n_ops++;
        start = 1'b1; frac_in = f; exp_in = e;
        @(negedge clk);
        start = 1'b0;
        if (intrude) begin
            repeat (3) @(negedge clk);
            start = 1'b1; frac_in = 5'b01011; exp_in = 5'd9;   // R10: ignored
            @(negedge clk);
            start = 1'b0;
        end
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R9", "held frac", int'(frac_out), int'(last.fr));
        chk("R9", "held exp",  int'(exp_out),  int'(last.ex));
    endtask

    // Monitor: pop and compare on each done pulse.
    always @(negedge clk) begin
        if (rst_n && done) begin
            item_t it;
            n_done++;
            if (sb.size() == 0) begin
                chk("R10", "unexpected done", 1, 0);
            end else begin
                it = sb.pop_front();
                chk(it.req, "frac", int'(frac_out), int'(it.fr));
                chk(it.req, "exp",  int'(exp_out),  int'(it.ex));
                chk("R7", "ovf", int'(ovf), int'(it.ov));
                chk("R8", "unf", int'(unf), int'(it.un));
                chk(it.req, "done cycle", cyc, it.due);
                chk("R6", "normalized", int'(frac_out == 0 || frac_out[4:3] == 2'b01), 1);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "frac after reset", int'(frac_out), 0);
        chk("R1", "exp after reset",  int'(exp_out), 0);
        chk("R1", "flags after reset", int'({ovf, unf}), 0);

        run_op(5'b01000, 5'd0,     "R2", 1'b0);   // 0.25: shift, exp -1
        run_op(5'b01111, 5'd3,     "R2", 1'b0);   // no shift
        run_op(5'b01100, 5'b11000, "R2", 1'b0);   // exp exactly -16
        run_op(5'b11000, 5'd2,     "R3", 1'b0);   // -0.5
        run_op(5'b10001, 5'b11111, "R3", 1'b0);   // -15/16
        run_op(5'b00000, 5'd7,     "R4", 1'b0);
        run_op(5'b10000, 5'd0,     "R5", 1'b0);
        run_op(5'b10000, 5'd15,    "R5", 1'b0);   // 31: overflow
        run_op(5'b01111, 5'd15,    "R7", 1'b0);   // 30
        run_op(5'b01101, 5'd8,     "R7", 1'b0);   // 16, just over
        run_op(5'b01000, 5'b11000, "R8", 1'b0);   // -17, just under
        run_op(5'b10000, 5'b10000, "R8", 1'b0);   // -31
        run_op(5'b01010, 5'd1,     "R10", 1'b1);  // second start ignored

        repeat (12) @(negedge clk);
        chk("R10", "done count", n_done, n_ops);
        chk("R9", "done low when idle", int'(done), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R9 watchdog: actual %0d dones expected %0d", n_done, n_ops);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule